// File: doc/BRIEF.md
# Lane Realignment Shifter with Return-Path Undo

This block sits between a vector message store and a check-node processing unit. Messages in the store are laid out for variable-node processing. A vector fetched for check-node work therefore has to be rotated across its lanes by an offset that can change on every access. The forward path applies that rotation, and the rotated vector goes on to the processing unit. When the processed vector comes back, the return path rotates it the other way by the same offset, so the store keeps its variable-node layout.

Each forward transfer pushes its offset into a small queue of shift amounts. Each return transfer pops the oldest entry. Processing can therefore take any number of cycles while forward and return vectors stay paired in first-in, first-out order. Both rotators are registered stages with valid/ready handshakes. A vector that returns when no offset is waiting is consumed, is not passed on, and raises an error pulse.

Top module: `lane_realign`

## Requirements
- R1: A vector is 64 lanes of 8 bits, and lane i occupies bits [8i+7:8i]. A forward transfer with shift s (6 bits) places input lane i at output lane (i + s) mod 64.
- R2: A return vector is rotated so that input lane i goes to output lane (i - s) mod 64. Here s is the oldest shift amount still queued from the forward path, so a vector sent forward and then returned comes back unchanged.
- R3: A shift amount of 0 passes the data through unchanged on both paths.
- R4: Each path has a latency of one cycle. After a handshake at a clock edge, the output is valid with the rotated data right after that edge.
- R5: While an output is valid and its ready is low, the output's valid and data hold steady, and that path's input ready is low.
- R6: The shift queue holds 16 entries. While 16 forward transfers have no matching return, the forward input ready is low and no forward transfer is accepted.
- R7: A return vector offered while the shift queue is empty is consumed (return input ready high) but never appears at the return output. The error output is high for exactly the one cycle after that handshake.
- R8: After reset, both output valids and the error output are low, the shift queue is empty, and both input readys are high.
- R9: Shift amounts pair with return vectors strictly in forward-transfer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_in_valid | input | 1 | Forward input vector valid |
| fwd_in_ready | output | 1 | Forward input accepted |
| fwd_in_data | input | 512 | Vector from the store |
| fwd_in_shift | input | 6 | Lane offset for this access |
| fwd_out_valid | output | 1 | Rotated vector valid |
| fwd_out_ready | input | 1 | Processing unit accepts the vector |
| fwd_out_data | output | 512 | Vector rotated for check-node processing |
| rtn_in_valid | input | 1 | Processed vector valid |
| rtn_in_ready | output | 1 | Processed vector accepted |
| rtn_in_data | input | 512 | Processed vector |
| rtn_out_valid | output | 1 | Restored vector valid |
| rtn_out_ready | input | 1 | Store accepts the restored vector |
| rtn_out_data | output | 512 | Vector in variable-node layout |
| rtn_err | output | 1 | Pulse: a return arrived with no queued shift |

## Verification
The hardest state to reach is a shift queue filled to exactly 16 outstanding offsets, each with a different value, and then drained in order. In that state a wrong pairing or a missing overflow stall is visible. The bench fills the queue with 16 forward transfers that use distinct offsets and distinct lane patterns. It offers a 17th transfer, which must be refused, and then returns the 16 rotated vectors and expects each original back. Forward and return behaviour is swept over all 64 offsets, and the empty-queue return and output backpressure are exercised separately.

// File: rtl/lane_rot_pkg.sv
package lane_rot_pkg;

    localparam int LANES      = 64;
    localparam int LANE_W     = 8;
    localparam int SHIFT_W    = $clog2(LANES);
    localparam int VEC_W      = LANES * LANE_W;
    localparam int FIFO_DEPTH = 16;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [SHIFT_W-1:0] shamt_t;

    typedef enum logic {ROT_UP, ROT_DOWN} rot_dir_e;

    typedef struct packed {
        logic valid;
        vec_t data;
    } beat_t;

    // ROT_UP: lane i -> lane (i+s) mod LANES; ROT_DOWN: lane i -> lane (i-s) mod LANES.
    // LANES is a power of two, so shamt_t arithmetic wraps modulo LANES.
    function automatic vec_t rotate_lanes(vec_t v, shamt_t s, rot_dir_e d);
        vec_t   r;
        shamt_t src;
        for (int j = 0; j < LANES; j++) begin
            if (d == ROT_UP) src = shamt_t'(j) - s;
            else             src = shamt_t'(j) + s;
            r[j*LANE_W +: LANE_W] = v[int'(src)*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/lane_rot_stage.sv
module lane_rot_stage
    import lane_rot_pkg::*;
#(
    parameter rot_dir_e DIR = ROT_UP
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    input  vec_t   in_data,
    input  shamt_t in_shift,
    output logic   out_valid,
    input  logic   out_ready,
    output vec_t   out_data
);

    beat_t beat_q;

    assign in_ready  = !beat_q.valid || out_ready;
    assign out_valid = beat_q.valid;
    assign out_data  = beat_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (in_ready) begin
            beat_q.valid <= in_valid;
            if (in_valid) beat_q.data <= rotate_lanes(in_data, in_shift, DIR);
        end
    end

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/lane_realign.sv
module lane_realign
    import lane_rot_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fwd_in_valid,
    output logic                fwd_in_ready,
    input  logic [VEC_W-1:0]    fwd_in_data,
    input  logic [SHIFT_W-1:0]  fwd_in_shift,
    output logic                fwd_out_valid,
    input  logic                fwd_out_ready,
    output logic [VEC_W-1:0]    fwd_out_data,
    input  logic                rtn_in_valid,
    output logic                rtn_in_ready,
    input  logic [VEC_W-1:0]    rtn_in_data,
    output logic                rtn_out_valid,
    input  logic                rtn_out_ready,
    output logic [VEC_W-1:0]    rtn_out_data,
    output logic                rtn_err
);

    logic   sh_full, sh_empty;
    logic   sh_push, sh_pop;
    shamt_t sh_head;
    logic   fwd_stage_ready, rtn_stage_ready;
    logic   err_q;

    // Forward path: accept only while the shift queue has room.
    assign fwd_in_ready = fwd_stage_ready && !sh_full;
    assign sh_push      = fwd_in_valid && fwd_in_ready;

    // Return path: consume always when the stage is free; rotate only with a queued shift.
    assign rtn_in_ready = rtn_stage_ready;
    assign sh_pop       = rtn_in_valid && rtn_in_ready && !sh_empty;

    shift_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (SHIFT_W)
    ) u_shq (
        .clk       (clk),
        .rst       (rst),
        .push      (sh_push),
        .push_data (fwd_in_shift),
        .pop       (sh_pop),
        .pop_data  (sh_head),
        .full      (sh_full),
        .empty     (sh_empty)
    );

    lane_rot_stage #(.DIR(ROT_UP)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (fwd_in_valid && !sh_full),
        .in_ready  (fwd_stage_ready),
        .in_data   (fwd_in_data),
        .in_shift  (fwd_in_shift),
        .out_valid (fwd_out_valid),
        .out_ready (fwd_out_ready),
        .out_data  (fwd_out_data)
    );

    lane_rot_stage #(.DIR(ROT_DOWN)) u_rtn (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rtn_in_valid && !sh_empty),
        .in_ready  (rtn_stage_ready),
        .in_data   (rtn_in_data),
        .in_shift  (sh_head),
        .out_valid (rtn_out_valid),
        .out_ready (rtn_out_ready),
        .out_data  (rtn_out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= rtn_in_valid && rtn_in_ready && sh_empty;
    end

    assign rtn_err = err_q;

endmodule

// File: rtl/lane_realign_chk.sv
module lane_realign_chk
    import lane_rot_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fwd_in_valid,
    input logic             fwd_in_ready,
    input logic             fwd_out_valid,
    input logic             fwd_out_ready,
    input logic [VEC_W-1:0] fwd_out_data,
    input logic             rtn_in_valid,
    input logic             rtn_in_ready,
    input logic             rtn_out_valid,
    input logic             rtn_out_ready,
    input logic [VEC_W-1:0] rtn_out_data,
    input logic             rtn_err
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [CW-1:0] outstanding;
    logic          fwd_hs, rtn_hs;

    assign fwd_hs = fwd_in_valid && fwd_in_ready;
    assign rtn_hs = rtn_in_valid && rtn_in_ready;

    always_ff @(posedge clk) begin
        if (rst) outstanding <= '0;
        else outstanding <= outstanding + CW'(fwd_hs)
                          - CW'(rtn_hs && outstanding != '0);
    end

    assert_reset_idle_R8: assert property (@(posedge clk)
        $past(rst) |-> (!fwd_out_valid && !rtn_out_valid && !rtn_err));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(outstanding) == FIFO_DEPTH) |-> !fwd_in_ready);

    assert_fwd_latency_R4: assert property (@(posedge clk) disable iff (rst)
        fwd_hs |=> fwd_out_valid);

    assert_rtn_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (rtn_hs && outstanding != '0) |=> rtn_out_valid);

    assert_fwd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (fwd_out_valid && !fwd_out_ready) |=> (fwd_out_valid && $stable(fwd_out_data)));

    assert_rtn_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (rtn_out_valid && !rtn_out_ready) |=> (rtn_out_valid && $stable(rtn_out_data)));

    assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (rtn_hs && outstanding == '0) |=> rtn_err);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        rtn_err |-> $past(rtn_hs && outstanding == '0));

endmodule

bind lane_realign lane_realign_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .fwd_in_valid  (fwd_in_valid),
    .fwd_in_ready  (fwd_in_ready),
    .fwd_out_valid (fwd_out_valid),
    .fwd_out_ready (fwd_out_ready),
    .fwd_out_data  (fwd_out_data),
    .rtn_in_valid  (rtn_in_valid),
    .rtn_in_ready  (rtn_in_ready),
    .rtn_out_valid (rtn_out_valid),
    .rtn_out_ready (rtn_out_ready),
    .rtn_out_data  (rtn_out_data),
    .rtn_err       (rtn_err)
);

// File: tb/lane_realign_test.sv
module lane_realign_test;
    import lane_rot_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwd_in_valid = 1'b0, fwd_out_ready = 1'b1;
    logic rtn_in_valid = 1'b0, rtn_out_ready = 1'b1;
    logic [VEC_W-1:0]   fwd_in_data = '0, rtn_in_data = '0;
    logic [SHIFT_W-1:0] fwd_in_shift = '0;
    logic fwd_in_ready, fwd_out_valid, rtn_in_ready, rtn_out_valid, rtn_err;
    logic [VEC_W-1:0] fwd_out_data, rtn_out_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lane_realign uut (.*);

    function automatic logic [VEC_W-1:0] pattern(int seed);
        logic [VEC_W-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*LANE_W +: LANE_W] = 8'((i * 7 + seed) % 256);
        return v;
    endfunction

    // Expected rotation: input lane i lands at lane (i + d) mod LANES.
    function automatic logic [VEC_W-1:0] move(logic [VEC_W-1:0] v, int d);
        logic [VEC_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[(((i + d) % LANES + LANES) % LANES)*LANE_W +: LANE_W] = v[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic chk_vec(input string tag, input logic [VEC_W-1:0] got, exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic fwd_push(input logic [VEC_W-1:0] d, input int s, input string tag);
        @(negedge clk);
        fwd_in_valid = 1'b1; fwd_in_data = d; fwd_in_shift = SHIFT_W'(s);
        @(posedge clk);
        @(negedge clk);
        fwd_in_valid = 1'b0;
        chk_bit({tag, " valid"}, fwd_out_valid, 1'b1);
        chk_vec({tag, " data"}, fwd_out_data, move(d, s));
    endtask

    task automatic rtn_push(input logic [VEC_W-1:0] d, input logic [VEC_W-1:0] exp, input string tag);
        @(negedge clk);
        rtn_in_valid = 1'b1; rtn_in_data = d;
        @(posedge clk);
        @(negedge clk);
        rtn_in_valid = 1'b0;
        chk_bit({tag, " valid"}, rtn_out_valid, 1'b1);
        chk_vec({tag, " data"}, rtn_out_data, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk_bit("R8 fwd_out_valid", fwd_out_valid, 1'b0);
        chk_bit("R8 rtn_out_valid", rtn_out_valid, 1'b0);
        chk_bit("R8 rtn_err", rtn_err, 1'b0);
        chk_bit("R8 fwd_in_ready", fwd_in_ready, 1'b1);
        chk_bit("R8 rtn_in_ready", rtn_in_ready, 1'b1);

        // R1/R2/R3/R4: sweep all shift amounts, forward then back
        for (int s = 0; s < LANES; s++) begin
            logic [VEC_W-1:0] base;
            base = pattern(s * 3);
            fwd_push(base, s, (s == 0) ? "R3 R1 R4 fwd" : "R1 R4 fwd");
            rtn_push(move(base, s), base, (s == 0) ? "R3 R2 rtn" : "R2 rtn");
        end

        // R6/R9: fill queue with distinct shifts
        for (int k = 0; k < FIFO_DEPTH; k++) fwd_push(pattern(100 + k), k * 3 + 1, "R9 fill");
        chk_bit("R6 ready low when full", fwd_in_ready, 1'b0);
        @(negedge clk);
        fwd_in_valid = 1'b1; fwd_in_data = pattern(7); fwd_in_shift = 6'd5;
        @(posedge clk);
        @(negedge clk);
        fwd_in_valid = 1'b0;
        chk_bit("R6 17th refused", fwd_out_valid, 1'b0);
        for (int k = 0; k < FIFO_DEPTH; k++)
            rtn_push(move(pattern(100 + k), k * 3 + 1), pattern(100 + k), "R9 drain order");

        // R7: return with an empty queue
        @(negedge clk);
        rtn_in_valid = 1'b1; rtn_in_data = pattern(55);
        chk_bit("R7 consumed", rtn_in_ready, 1'b1);
        @(posedge clk);
        @(negedge clk);
        rtn_in_valid = 1'b0;
        chk_bit("R7 no output", rtn_out_valid, 1'b0);
        chk_bit("R7 err pulse", rtn_err, 1'b1);
        @(negedge clk);
        chk_bit("R7 err one cycle", rtn_err, 1'b0);

        // R5: forward backpressure
        fwd_out_ready = 1'b0;
        fwd_push(pattern(9), 17, "R5 fwd load");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk_bit("R5 fwd hold valid", fwd_out_valid, 1'b1);
            chk_vec("R5 fwd hold data", fwd_out_data, move(pattern(9), 17));
            chk_bit("R5 fwd in stalled", fwd_in_ready, 1'b0);
        end
        fwd_out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_bit("R5 fwd released", fwd_out_valid, 1'b0);

        // R5: return backpressure, also drains the queued shift
        rtn_out_ready = 1'b0;
        rtn_push(move(pattern(9), 17), pattern(9), "R5 rtn load");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk_bit("R5 rtn hold valid", rtn_out_valid, 1'b1);
            chk_vec("R5 rtn hold data", rtn_out_data, pattern(9));
            chk_bit("R5 rtn in stalled", rtn_in_ready, 1'b0);
        end
        rtn_out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_bit("R5 rtn released", rtn_out_valid, 1'b0);

        finish_run();
    end

endmodule